// File: doc/BRIEF.md
# Memory-Mapped Control and Status Register Bank

This block is a small bank of 32-bit registers on a plain synchronous bus with a byte address, write data, a per-lane write enable and single-cycle read and write strobes. Each field of each register has one access mode, and its value travels to or from the surrounding hardware on its own port. Reads are combinational: the read data in a cycle reflects the address and the hardware inputs of that same cycle.

Four registers make up the map. The control word (offset 0x0) holds an 8-bit mode field in bits [7:0] and an enable bit in bit 8; both are stored and driven out, but a read returns separate hardware-supplied copies of them. The status word (offset 0x4) returns a 16-bit hardware value in bits [15:0]. The command word (offset 0x8) holds four handshake request bits in [3:0]: a write loads them, and each acknowledge bit clears only its own request. The data word (offset 0xC) is a 32-bit write-only value, and every read of it raises a one-cycle notify strobe.

A parameter chooses whether register selects are decoded straight from the address or registered from an address presented one cycle ahead of the strobes. The default is straight decode.

Top module: `csr_bank`

## Requirements
- R1: Every stored field (control mode, control enable, command requests, data word) is zero after a synchronous active-high reset, whenever reset is applied.
- R2: A write to offset 0x0 stores bits [7:0] into `ctl_mode_q` and bit 8 into `ctl_en_q`; a read of offset 0x0 returns `ctl_mode_hw` in [7:0], `ctl_en_hw` in bit 8 and zero above, not the stored copy.
- R3: A write changes only the bits that lie in byte lanes whose `bus_be` bit is set (lane k covers bits [8k+7:8k]); the control enable bit lies in lane 1.
- R4: A read of offset 0x4 returns `sts_hw` in [15:0] with zero above; a write to offset 0x4 changes no output.
- R5: A write to offset 0x8 with lane 0 enabled loads `cmd_req` from write data [3:0]; in any cycle without such a write each request bit is cleared by its own `cmd_ack` bit and otherwise holds. A read of offset 0x8 returns `cmd_hw` in [3:0] with zero above.
- R6: When a write to a request bit and its acknowledge arrive in the same cycle, the written value is stored.
- R7: A write to offset 0xC stores into `dat_q` lane by lane; a read of offset 0xC returns zero.
- R8: `dat_rd_notify` is high in exactly the cycles where `bus_rd` is high and the address selects offset 0xC.
- R9: Address bits [1:0] are ignored by the decode: any byte address inside a word selects that word.
- R10: Addresses from 0x10 up select no register: they read as zero and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Byte address (one cycle early when selects are registered) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Per-lane write enable, bit k for bits [8k+7:8k] |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Combinational read data |
| ctl_mode_q | output | 8 | Stored control mode field |
| ctl_en_q | output | 1 | Stored control enable bit |
| ctl_mode_hw | input | 8 | Value returned for the mode field on reads |
| ctl_en_hw | input | 1 | Value returned for the enable bit on reads |
| sts_hw | input | 16 | Status value returned on reads |
| cmd_req | output | 4 | Handshake request bits |
| cmd_ack | input | 4 | Per-bit acknowledge, clears the matching request |
| cmd_hw | input | 4 | Value returned for the command field on reads |
| dat_q | output | 32 | Stored write-only data word |
| dat_rd_notify | output | 1 | High while the data word is being read |

## Verification
The assertions assume that `cmd_ack` is the only thing that can lower a request outside a command write, and that hardware-supplied read values may change freely from cycle to cycle, so they constrain stored state and decode rather than read data of mapped words. They also take for granted that reset is synchronous and held for at least one clock edge. The stimulus changes every input on the falling edge, never raises both strobes at once, and keeps `cmd_ack` low except in the cycles where clearing or the write-versus-acknowledge race is meant to be exercised.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int CSR_SLOTS = 4;

  typedef enum logic [1:0] {
    SLOT_CTL = 2'd0,
    SLOT_STS = 2'd1,
    SLOT_CMD = 2'd2,
    SLOT_DAT = 2'd3
  } csr_slot_e;
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int WA        = 3,
  parameter int NREGS     = 4,
  parameter bit SEL_EARLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WA-1:0]    word_addr,
  output logic [NREGS-1:0] sel
);
  logic [NREGS-1:0] dec;

  always_comb begin
    for (int i = 0; i < NREGS; i++) dec[i] = (word_addr == WA'(i));
  end

  if (SEL_EARLY) begin : g_flop
    logic [NREGS-1:0] sel_r;
    always_ff @(posedge clk) begin
      if (rst) sel_r <= '0;
      else     sel_r <= dec;
    end
    assign sel = sel_r;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign sel = dec;
  end
endmodule

// File: rtl/csr_field.sv
module csr_field #(
  parameter int W         = 1,
  parameter bit HANDSHAKE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] we_bits,
  input  logic [W-1:0] d,
  input  logic [W-1:0] ack,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r, nxt;
    if (HANDSHAKE) begin : g_hs
      assign nxt = we_bits[i] ? d[i] : (r & ~ack[i]);
    end else begin : g_plain
      assign nxt = we_bits[i] ? d[i] : r;
    end
    always_ff @(posedge clk) begin
      if (rst) r <= 1'b0;
      else     r <= nxt;
    end
    assign q[i] = r;
  end

  if (!HANDSHAKE) begin : g_noack
    logic unused_ack;
    assign unused_ack = ^ack;
  end
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 4
) (
  input  logic [NREGS-1:0]             sel,
  input  logic [NREGS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (sel[i]) rdata = rdata | words[i];
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LANE_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int CTL_MODE_W = 8,
  parameter int STS_W      = 16,
  parameter int CMD_W      = 4,
  parameter bit SEL_EARLY  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W/LANE_W-1:0] bus_be,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [CTL_MODE_W-1:0] ctl_mode_q,
  output logic                  ctl_en_q,
  input  logic [CTL_MODE_W-1:0] ctl_mode_hw,
  input  logic                  ctl_en_hw,
  input  logic [STS_W-1:0]      sts_hw,
  output logic [CMD_W-1:0]      cmd_req,
  input  logic [CMD_W-1:0]      cmd_ack,
  input  logic [CMD_W-1:0]      cmd_hw,
  output logic [DATA_W-1:0]     dat_q,
  output logic                  dat_rd_notify
);
  localparam int LANES   = DATA_W / LANE_W;
  localparam int LANE_AW = $clog2(LANES);
  localparam int WA      = ADDR_W - LANE_AW;
  localparam int NREGS   = CSR_SLOTS;
  localparam int CTL_W   = CTL_MODE_W + 1;

  // Spread per-lane enables onto every data bit of the lane.
  function automatic logic [DATA_W-1:0] lane_to_bits(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = be[b / LANE_W];
    return m;
  endfunction

  logic [WA-1:0]     word_addr;
  logic              unused_lane_addr;
  logic [NREGS-1:0]  sel;
  logic [NREGS-1:0]  wr_hit;
  logic [DATA_W-1:0] we_mask;
  logic [NREGS-1:0][DATA_W-1:0] rd_words;

  assign word_addr        = bus_addr[ADDR_W-1:LANE_AW];
  assign unused_lane_addr = ^bus_addr[LANE_AW-1:0];
  assign we_mask          = lane_to_bits(bus_be);
  assign wr_hit           = sel & {NREGS{bus_wr}};

  csr_decode #(.WA(WA), .NREGS(NREGS), .SEL_EARLY(SEL_EARLY)) u_decode (
    .clk(clk), .rst(rst), .word_addr(word_addr), .sel(sel)
  );

  // Control word: mode field and enable bit, both read/write.
  logic [CTL_W-1:0] ctl_q;
  csr_field #(.W(CTL_W), .HANDSHAKE(1'b0)) u_ctl (
    .clk(clk), .rst(rst),
    .we_bits(we_mask[CTL_W-1:0] & {CTL_W{wr_hit[SLOT_CTL]}}),
    .d(bus_wdata[CTL_W-1:0]), .ack('0), .q(ctl_q)
  );
  assign ctl_mode_q = ctl_q[CTL_MODE_W-1:0];
  assign ctl_en_q   = ctl_q[CTL_MODE_W];

  // Command word: handshake requests.
  csr_field #(.W(CMD_W), .HANDSHAKE(1'b1)) u_cmd (
    .clk(clk), .rst(rst),
    .we_bits(we_mask[CMD_W-1:0] & {CMD_W{wr_hit[SLOT_CMD]}}),
    .d(bus_wdata[CMD_W-1:0]), .ack(cmd_ack), .q(cmd_req)
  );

  // Data word: write-only.
  csr_field #(.W(DATA_W), .HANDSHAKE(1'b0)) u_dat (
    .clk(clk), .rst(rst),
    .we_bits(we_mask & {DATA_W{wr_hit[SLOT_DAT]}}),
    .d(bus_wdata), .ack('0), .q(dat_q)
  );

  assign rd_words[SLOT_CTL] = DATA_W'({ctl_en_hw, ctl_mode_hw});
  assign rd_words[SLOT_STS] = DATA_W'(sts_hw);
  assign rd_words[SLOT_CMD] = DATA_W'(cmd_hw);
  assign rd_words[SLOT_DAT] = '0;

  csr_rdmux #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rdmux (
    .sel(sel), .words(rd_words), .rdata(bus_rdata)
  );

  assign dat_rd_notify = sel[SLOT_DAT] & bus_rd;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int DATA_W     = 32,
  parameter int NREGS      = 4,
  parameter int CTL_MODE_W = 8,
  parameter int CMD_W      = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NREGS-1:0]      sel,
  input logic [NREGS-1:0]      wr_hit,
  input logic                  bus_rd,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [CTL_MODE_W-1:0] ctl_mode_q,
  input logic                  ctl_en_q,
  input logic [CMD_W-1:0]      cmd_req,
  input logic [CMD_W-1:0]      cmd_ack,
  input logic [DATA_W-1:0]     dat_q,
  input logic                  dat_rd_notify
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sel)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) (sel == '0) |-> (bus_rdata == '0)); // R10
  AST_DAT_READ_ZERO: assert property (@(posedge clk) disable iff (rst) sel[3] |-> (bus_rdata == '0)); // R7
  AST_NOTIFY_NEEDS_RD: assert property (@(posedge clk) disable iff (rst) dat_rd_notify |-> bus_rd); // R8
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_hit[0] |=> $stable({ctl_en_q, ctl_mode_q})); // R2
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_hit[3] |=> $stable(dat_q)); // R7
  AST_CMD_NO_SET: assert property (@(posedge clk) disable iff (rst) !wr_hit[2] |=> ((cmd_req & ~$past(cmd_req)) == '0)); // R5
  AST_CMD_ACK_CLR: assert property (@(posedge clk) disable iff (rst) !wr_hit[2] |=> ((cmd_req & $past(cmd_ack)) == '0)); // R5
endmodule

bind csr_bank csr_bank_chk #(
  .DATA_W(DATA_W), .NREGS(NREGS), .CTL_MODE_W(CTL_MODE_W), .CMD_W(CMD_W)
) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_hit(wr_hit), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .ctl_mode_q(ctl_mode_q), .ctl_en_q(ctl_en_q),
  .cmd_req(cmd_req), .cmd_ack(cmd_ack), .dat_q(dat_q),
  .dat_rd_notify(dat_rd_notify)
);

// File: tb/csr_bank_tb.sv
`timescale 1ns/1ps
module csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  ctl_mode_q;
  logic        ctl_en_q;
  logic [7:0]  ctl_mode_hw = '0;
  logic        ctl_en_hw = 1'b0;
  logic [15:0] sts_hw = '0;
  logic [3:0]  cmd_req;
  logic [3:0]  cmd_ack = '0;
  logic [3:0]  cmd_hw = '0;
  logic [31:0] dat_q;
  logic        dat_rd_notify;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csr_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ctl_mode_q(ctl_mode_q), .ctl_en_q(ctl_en_q), .ctl_mode_hw(ctl_mode_hw),
    .ctl_en_hw(ctl_en_hw), .sts_hw(sts_hw), .cmd_req(cmd_req),
    .cmd_ack(cmd_ack), .cmd_hw(cmd_hw), .dat_q(dat_q),
    .dat_rd_notify(dat_rd_notify)
  );

  // {addr[4:0], be[3:0], wdata[31:0], expected stored value of that word}
  localparam logic [72:0] VEC [0:8] = '{
    {5'h00, 4'hF, 32'h0000_01A5, 32'h0000_01A5},
    {5'h00, 4'h1, 32'h0000_003C, 32'h0000_013C},
    {5'h00, 4'h2, 32'h0000_0000, 32'h0000_003C},
    {5'h0C, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h0C, 4'h4, 32'h0011_0000, 32'hDE11_BEEF},
    {5'h0F, 4'h8, 32'h7700_0000, 32'h7711_BEEF},
    {5'h08, 4'h1, 32'h0000_000A, 32'h0000_000A},
    {5'h0A, 4'hE, 32'h0000_0005, 32'h0000_000A},
    {5'h01, 4'h3, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stored_word(input logic [4:0] a);
    case (a[4:2])
      3'd0:    return {23'b0, ctl_en_q, ctl_mode_q};
      3'd2:    return {28'b0, cmd_req};
      3'd3:    return dat_q;
      default: return 32'h0;
    endcase
  endfunction

  task automatic do_write(input logic [4:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic [3:0] ack);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1; cmd_ack = ack;
    @(negedge clk);
    bus_wr = 1'b0; cmd_ack = '0; bus_be = '0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [31:0] d, output logic nt);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    d = bus_rdata; nt = dat_rd_notify;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic all_zero(input string req);
    check(req, {23'b0, ctl_en_q, ctl_mode_q}, 32'h0);
    check(req, {28'b0, cmd_req}, 32'h0);
    check(req, dat_q, 32'h0);
  endtask

  initial begin
    logic [31:0] rd;
    logic        nt;
    repeat (3) @(negedge clk);
    all_zero("R1 after reset");
    rst = 1'b0;

    // Vector table: R2 R3 R7 R9 (and R5 load through lane 0)
    for (int i = 0; i < 9; i++) begin
      do_write(VEC[i][72:68], VEC[i][67:64], VEC[i][63:32], 4'h0);
      check($sformatf("R2/R3/R5/R7/R9 vector %0d", i), stored_word(VEC[i][72:68]), VEC[i][31:0]);
    end

    // R2: read returns hardware copy, not stored value
    ctl_mode_hw = 8'h5A; ctl_en_hw = 1'b1; sts_hw = 16'hBEEF; cmd_hw = 4'h9;
    do_read(5'h00, rd, nt);
    check("R2 control read", rd, 32'h0000_015A);
    check("R8 no notify on control read", {31'b0, nt}, 32'h0);
    // R4 status read, with R9 offset
    do_read(5'h04, rd, nt);
    check("R4 status read", rd, 32'h0000_BEEF);
    do_read(5'h06, rd, nt);
    check("R9 status read at 0x6", rd, 32'h0000_BEEF);
    // R4 write to status has no effect
    do_write(5'h04, 4'hF, 32'hFFFF_FFFF, 4'h0);
    check("R4 ctl unchanged", {23'b0, ctl_en_q, ctl_mode_q}, 32'h0);
    check("R4 cmd unchanged", {28'b0, cmd_req}, 32'hA);
    check("R4 dat unchanged", dat_q, 32'h7711_BEEF);
    // R5 command read
    do_read(5'h08, rd, nt);
    check("R5 command read", rd, 32'h0000_0009);

    // R5 acknowledge clears only its bit
    @(negedge clk); cmd_ack = 4'h2;
    @(negedge clk); cmd_ack = 4'h0;
    check("R5 ack clears bit1", {28'b0, cmd_req}, 32'h8);
    @(negedge clk);
    check("R5 holds without ack", {28'b0, cmd_req}, 32'h8);
    // R6 write wins over ack
    do_write(5'h08, 4'h1, 32'h8, 4'h8);
    check("R6 write beats ack bit3", {28'b0, cmd_req}, 32'h8);
    do_write(5'h08, 4'h1, 32'h3, 4'h1);
    check("R6 write beats ack bit0", {28'b0, cmd_req}, 32'h3);
    @(negedge clk); cmd_ack = 4'hF;
    @(negedge clk); cmd_ack = 4'h0;
    check("R5 full ack clears all", {28'b0, cmd_req}, 32'h0);

    // R7 data reads as zero, R8 notify
    do_read(5'h0C, rd, nt);
    check("R7 data read zero", rd, 32'h0);
    check("R8 notify on data read", {31'b0, nt}, 32'h1);
    do_read(5'h0D, rd, nt);
    check("R8 R9 notify at 0xD", {31'b0, nt}, 32'h1);
    @(negedge clk); bus_addr = 5'h0C; bus_rd = 1'b0; #2;
    check("R8 no notify without strobe", {31'b0, dat_rd_notify}, 32'h0);

    // R10 unmapped
    do_read(5'h14, rd, nt);
    check("R10 unmapped read", rd, 32'h0);
    check("R8 no notify unmapped", {31'b0, nt}, 32'h0);
    do_write(5'h10, 4'hF, 32'hFFFF_FFFF, 4'h0);
    do_write(5'h1C, 4'hF, 32'hFFFF_FFFF, 4'h0);
    check("R10 ctl unchanged", {23'b0, ctl_en_q, ctl_mode_q}, 32'h0);
    check("R10 cmd unchanged", {28'b0, cmd_req}, 32'h0);
    check("R10 dat unchanged", dat_q, 32'h7711_BEEF);

    // R1 reset mid-run
    do_write(5'h00, 4'hF, 32'h0000_01FF, 4'h0);
    do_write(5'h08, 4'hF, 32'h0000_000F, 4'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    all_zero("R1 reset mid-run");
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule